// File: doc/BRIEF.md
# Dual Gamepad Serial Port

This block gives a CPU two gamepad ports on its memory bus. Each port holds eight button states. A write to the strobe address sets a shared strobe flag from bit 0 of the written data. While the flag is high, both ports keep copying their live button vectors. When the flag drops, the copied values stay frozen. After that, each read of a port's address returns one button in bit 0 and moves that port on to the next button.

The read data is built in the same cycle as `rd_i`. Bit 0 comes from the selected port. The upper bits come from `open_bus_i`, which the system feeds with the last byte seen on the data bus. Reads of other addresses return `open_bus_i` unchanged. A port moves to its next button when a read access to it ends, not while the read is still going on. This lets a read held over several cycles return one steady value.

Top module: `gpad_serial_port`

## Requirements
- R1: After reset the strobe is low and every port's latched state is all ones, so a port read returns 1 in bit 0.
- R2: A write to 0x4016 sets the strobe to bit 0 of `wdata_i`, and the other data bits are ignored. The button values are frozen from the live vector present in the cycle of the write that lowers the strobe. This holds even when a read ended in that same cycle.
- R3: After the freeze, successive reads of a port return the `pads_i` bits of that port in order from index 0 to index 7 in bit 0 (0=A, 1=B, 2=Select, 3=Start, 4=Up, 5=Down, 6=Left, 7=Right).
- R4: Once eight bits have been read with the strobe low, every further read returns 1 in bit 0.
- R5: While the strobe is high, a port read returns that port's live `pads_i` bit 0 in the same cycle, and the port does not advance.
- R6: Port 0 is at 0x4016 and uses `pads_i[7:0]`. Port 1 is at 0x4017 and uses `pads_i[15:8]`. Each port keeps its own read position.
- R7: During a port read, `rdata_o[7:1]` equals `open_bus_i[7:1]`.
- R8: Reads of any address other than the port addresses return `open_bus_i` and advance no port. Writes to any address other than 0x4016 leave the strobe unchanged.
- R9: A port advances by one position when a read access to it ends. Holding `rd_i` high over several cycles returns the same bit in every one of them.
- R10: When `rd_i` is low, `rdata_o` equals `open_bus_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read access active |
| wr_i | input | 1 | Write access active |
| pads_i | input | 16 | Live buttons, port 0 in [7:0], port 1 in [15:8], 1 = pressed |
| open_bus_i | input | 8 | Last byte driven on the data bus |
| rdata_o | output | 8 | Read data |

## Verification
Two actions can land on the same clock edge: the step forward that ends a port read, and the reload of the live buttons while the strobe is high. The clash happens when a port read made with the strobe high is followed at once by the write that lowers the strobe. The button vector is changed in that write cycle. The check is that the reads which follow return the new vector from A onward, with nothing skipped. A reference model in the bench also runs this case many times under random mixes of reads, writes and button changes.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
  localparam int unsigned PAD_ADDR_W  = 16;
  localparam int unsigned PAD_DATA_W  = 8;
  localparam int unsigned PAD_PORTS   = 2;
  localparam int unsigned PAD_BUTTONS = 8;
  localparam logic [PAD_ADDR_W-1:0] PAD_BASE_ADDR = 16'h4016;

  // bit position of each button inside a port vector; shift-out order follows it
  typedef enum int unsigned {
    BTN_A      = 0,
    BTN_B      = 1,
    BTN_SELECT = 2,
    BTN_START  = 3,
    BTN_UP     = 4,
    BTN_DOWN   = 5,
    BTN_LEFT   = 6,
    BTN_RIGHT  = 7
  } btn_e;
endpackage

// File: rtl/gpad_decode.sv
module gpad_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORTS  = 2,
  parameter logic [ADDR_W-1:0] BASE = 16'h4016
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              strobe_we_o,
  output logic [PORTS-1:0]  port_rd_o,
  output logic              port_hit_o
);
  logic [PORTS-1:0] hit;

  for (genvar p = 0; p < PORTS; p++) begin : g_hit
    assign hit[p] = (addr_i == BASE + ADDR_W'(p));
  end

  assign port_rd_o   = hit & {PORTS{rd_i}};
  assign port_hit_o  = |hit;
  assign strobe_we_o = wr_i & hit[0];
endmodule

// File: rtl/gpad_strobe.sv
module gpad_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic bit_i,
  output logic strobe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   strobe_o <= 1'b0;
    else if (we_i) strobe_o <= bit_i;
  end

  // R2
  strobe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> strobe_o == $past(bit_i));

  // R8
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(strobe_o));
endmodule

// File: rtl/gpad_shifter.sv
module gpad_shifter #(
  parameter int unsigned BUTTONS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic               rd_hit_i,
  input  logic [BUTTONS-1:0] pad_i,
  output logic               bit_o
);
  logic [BUTTONS-1:0] sr_q;
  logic               pend_q;
  logic               rd_end;

  assign rd_end = pend_q & ~rd_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      pend_q <= 1'b0;
    end else begin
      pend_q <= rd_hit_i;
      // live reload wins over a read that ends on the same edge
      if (strobe_i)    sr_q <= pad_i;
      else if (rd_end) sr_q <= {1'b1, sr_q[BUTTONS-1:1]};
    end
  end

  assign bit_o = strobe_i ? pad_i[0] : sr_q[0];

  // R2
  live_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> sr_q == $past(pad_i));

  // R3
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && pend_q && !rd_hit_i) |=> sr_q == {1'b1, $past(sr_q[BUTTONS-1:1])});

  // R4
  exhaust_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && (&sr_q)) |=> (&sr_q));

  // R9
  held_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && rd_hit_i) |=> $stable(sr_q));
endmodule

// File: rtl/gpad_rdmux.sv
module gpad_rdmux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PORTS  = 2
) (
  input  logic [PORTS-1:0]  port_rd_i,
  input  logic [PORTS-1:0]  port_bit_i,
  input  logic [DATA_W-1:0] open_bus_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = open_bus_i;
    for (int p = 0; p < PORTS; p++) begin
      if (port_rd_i[p]) rdata_o[0] = port_bit_i[p];
    end
  end
endmodule

// File: rtl/gpad_serial_port.sv
module gpad_serial_port
  import gpad_pkg::*;
#(
  parameter int unsigned ADDR_W  = PAD_ADDR_W,
  parameter int unsigned DATA_W  = PAD_DATA_W,
  parameter int unsigned PORTS   = PAD_PORTS,
  parameter int unsigned BUTTONS = PAD_BUTTONS,
  parameter logic [ADDR_W-1:0] BASE = PAD_BASE_ADDR
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [PORTS*BUTTONS-1:0] pads_i,
  input  logic [DATA_W-1:0]        open_bus_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic             strobe_we;
  logic             strobe_q;
  logic [PORTS-1:0] port_rd;
  logic [PORTS-1:0] port_bit;
  logic             port_hit;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  gpad_decode #(.ADDR_W(ADDR_W), .PORTS(PORTS), .BASE(BASE)) u_decode (
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .strobe_we_o (strobe_we),
    .port_rd_o   (port_rd),
    .port_hit_o  (port_hit)
  );

  gpad_strobe u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (strobe_we),
    .bit_i    (wdata_i[0]),
    .strobe_o (strobe_q)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpad_shifter #(.BUTTONS(BUTTONS)) u_shifter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_q),
      .rd_hit_i (port_rd[p]),
      .pad_i    (pads_i[p*BUTTONS +: BUTTONS]),
      .bit_o    (port_bit[p])
    );
  end

  gpad_rdmux #(.DATA_W(DATA_W), .PORTS(PORTS)) u_rdmux (
    .port_rd_i  (port_rd),
    .port_bit_i (port_bit),
    .open_bus_i (open_bus_i),
    .rdata_o    (rdata_o)
  );

  // R7
  upper_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && port_hit) |-> rdata_o[DATA_W-1:1] == open_bus_i[DATA_W-1:1]);

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !port_hit) |-> rdata_o == open_bus_i);

  // R5
  live_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && rd_i && addr_i == BASE) |-> rdata_o[0] == pads_i[0]);

  // R10
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == open_bus_i);
endmodule

// File: tb/gpad_serial_port_bench.sv
module gpad_serial_port_bench;
  localparam logic [15:0] A0 = 16'h4016;
  localparam logic [15:0] A1 = 16'h4017;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] pads = '0;
  logic [7:0]  open_bus = '0;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpad_serial_port u_gpad_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .pads_i(pads), .open_bus_i(open_bus), .rdata_o(rdata)
  );

  // reference model from the requirements
  logic [7:0] m_sr [2];
  logic       m_strobe;
  logic [1:0] m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr[0] <= 8'hFF; m_sr[1] <= 8'hFF; m_strobe <= 1'b0; m_pend <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_pend[p] <= rd && (addr == A0 + 16'(p));
        if (m_strobe) m_sr[p] <= pads[p*8 +: 8];
        else if (m_pend[p] && !(rd && addr == A0 + 16'(p)))
          m_sr[p] <= {1'b1, m_sr[p][7:1]};
      end
      if (wr && addr == A0) m_strobe <= wdata[0];
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!rd) return open_bus;
    if (addr == A0 || addr == A1) begin
      int   p = (addr == A1) ? 1 : 0;
      logic b = m_strobe ? pads[p*8] : m_sr[p][0];
      return {open_bus[7:1], b};
    end
    return open_bus;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_op(logic [15:0] a, string tag);
    addr = a; rd = 1'b1; wr = 1'b0;
    #1 chk(tag, rdata, exp_rdata());
    @(negedge clk); rd = 1'b0;
    #1 chk("R10", rdata, open_bus);
    @(negedge clk);
  endtask

  task automatic rd_exp(logic [15:0] a, logic [7:0] e, string tag);
    addr = a; rd = 1'b1; wr = 1'b0;
    #1 chk(tag, rdata, e);
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_op(logic [15:0] a, logic [7:0] v);
    addr = a; wdata = v; wr = 1'b1; rd = 1'b0;
    @(negedge clk); wr = 1'b0;
  endtask

  initial begin
    logic [7:0] seq;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    open_bus = 8'h00;
    rd_exp(A0, 8'h01, "R1");
    rd_exp(A1, 8'h01, "R1");

    // R3 order, R2 freeze, R4 exhaustion, R6 second port
    pads = {8'h02, 8'h45};
    wr_op(A0, 8'h01);
    wr_op(A0, 8'h00);
    pads = 16'hFFFF;
    seq = 8'h45;
    for (int i = 0; i < 8; i++) rd_exp(A0, {7'h00, seq[i]}, "R3");
    rd_exp(A0, 8'h01, "R4");
    rd_exp(A0, 8'h01, "R4");
    rd_exp(A1, 8'h00, "R6");
    rd_exp(A1, 8'h01, "R6");

    // R5 live A while strobe high
    wr_op(A0, 8'h01);
    pads[7:0] = 8'h01;
    rd_exp(A0, 8'h01, "R5");
    rd_exp(A0, 8'h01, "R5");
    pads[7:0] = 8'h00;
    rd_exp(A0, 8'h00, "R5");

    // R7 open-bus upper bits
    pads[7:0] = 8'h01;
    wr_op(A0, 8'h00);
    open_bus = 8'hE0;
    rd_exp(A0, 8'hE1, "R7");

    // R8 unmapped reads: return bus, no advance
    open_bus = 8'h5A;
    rd_exp(16'h4018, 8'h5A, "R8");
    rd_exp(16'h4018, 8'h5A, "R8");
    rd_exp(16'h0000, 8'h5A, "R8");
    for (int i = 0; i < 7; i++) rd_exp(A0, 8'h5A, "R8");
    rd_exp(A0, 8'h5B, "R4");
    // write elsewhere must not raise strobe
    wr_op(A1, 8'h01);
    pads[7:0] = 8'h00;
    rd_exp(A0, 8'h5B, "R8");

    // R9 held read returns one bit, advances once
    open_bus = 8'h00;
    pads[7:0] = 8'h06;
    wr_op(A0, 8'h01);
    wr_op(A0, 8'h00);
    addr = A0; rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R9", rdata, 8'h00);
      @(negedge clk);
    end
    rd = 1'b0;
    @(negedge clk);
    rd_exp(A0, 8'h01, "R9");
    rd_exp(A0, 8'h01, "R9");
    rd_exp(A0, 8'h00, "R9");

    // R2 other data bits ignored
    wr_op(A0, 8'h01);
    pads[7:0] = 8'h01;
    wr_op(A0, 8'hFE);
    pads[7:0] = 8'h00;
    rd_exp(A0, 8'h01, "R2");

    // R2 read end and freeze on the same edge: reload wins
    wr_op(A0, 8'h01);
    pads[7:0] = 8'h01;
    addr = A0; rd = 1'b1;
    #1 chk("R5", rdata, 8'h01);
    @(negedge clk);
    rd = 1'b0; wr = 1'b1; wdata = 8'h00; pads[7:0] = 8'h3D;
    @(negedge clk);
    wr = 1'b0;
    rd_exp(A0, 8'h01, "R2");
    rd_exp(A0, 8'h00, "R2");
    rd_exp(A0, 8'h01, "R2");
    rd_exp(A0, 8'h01, "R2");

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      pads = 16'($urandom);
      open_bus = 8'($urandom);
      case ($urandom % 8)
        0:       wr_op(A0, 8'($urandom));
        1:       wr_op(A0 + 16'($urandom % 4), 8'($urandom));
        2, 3:    rd_op(A0, "R3");
        4, 5:    rd_op(A1, "R6");
        6:       rd_op(A0 + 16'd2, "R8");
        default: begin
          #1 chk("R10", rdata, open_bus);
          @(negedge clk);
        end
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule